// File: doc/BRIEF.md
# Gated Programmable Duty Clock Divider

This block derives a slower sample clock from a fast input clock. A divider field picks the period and a high-time field picks how many input cycles of each period the output spends high. The duty cycle can therefore be set apart from the period instead of being fixed near one half. Writing zero to the divider field stops the output, and a status output reports whether the divider is currently running.

Both fields are sampled only at period boundaries. Software can rewrite them while the clock runs without producing a shortened pulse. Leaving the stopped state always starts a fresh period with its high phase. The output comes straight from a flip-flop clocked by the input clock, so it only moves on input rising edges. A build parameter can drop the high-time field, and the output then runs at about half duty.

Top module: `sample_clk_div`

## Requirements
- R1: When `div_val` is 0, `clk_out` is low from the next input rising edge onward, and it stays low while `div_val` remains 0. Gating takes effect at once, even in the middle of a period.
- R2: `running` is 1 exactly when `div_val` is non-zero. It follows `div_val` combinationally, within the same cycle.
- R3: With `div_val` = N (N ≥ 1) and `high_val` = H ≤ N, `clk_out` repeats with a period of N+1 input cycles. In each period it is high for the first H+1 cycles and low for the remaining N−H cycles. This covers the smallest ratio, 2, and the largest ratio, 2^W.
- R4: If `high_val` is greater than `div_val`, the high phase is clamped to the whole period, and `clk_out` stays high.
- R5: When `div_val` turns non-zero from the stopped state, the first rising edge that samples it drives `clk_out` high, and that edge starts a new period.
- R6: Values written to `div_val` or `high_val` in the middle of a period leave the current period unchanged. The new values apply from the next period boundary.
- R7: When parameter `HAS_HIGH` = 0, `high_val` is ignored. The output is then high for floor(N/2)+1 cycles and low for the rest of each N+1-cycle period.
- R8: After reset is asserted, `clk_out` is low. With `div_val` = 0, `running` is also 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_val | input | W | Divider field; 0 gates the output, N gives a period of N+1 cycles |
| high_val | input | W | High-time field; the output is high for H+1 cycles of each period |
| clk_out | output | 1 | Divided clock, driven from a register |
| running | output | 1 | High when the divider field is non-zero |

## Verification
Inputs are driven on falling edges. A new `div_val` that follows a stop is taken at the next rising edge, so the bench reads the first high sample at the falling edge that comes right after it. It then walks one sample per falling edge through N+1 slots per period. `running` is combinational and is checked a fraction of a nanosecond after the input changes. A mid-period rewrite is expected to show up only in the slot after the old period's last low sample. A gate request is expected to pull `clk_out` low at the very next falling edge.

// File: rtl/sample_clk_div.sv
module sample_clk_div #(
  parameter int W        = 8,
  parameter bit HAS_HIGH = 1'b1
) (
  input  logic         clk_in,
  input  logic         rst_n,
  input  logic [W-1:0] div_val,
  input  logic [W-1:0] high_val,
  output logic         clk_out,
  output logic         running
);

  logic         active;
  logic [W-1:0] cnt, cnt_nx, div_q, high_q, high_eff;
  logic         wrap;

  assign running = |div_val;
  assign cnt_nx  = cnt + W'(1);
  assign wrap    = (cnt == div_q);

  generate
    if (HAS_HIGH) begin : g_prog
      assign high_eff = (high_q > div_q) ? div_q : high_q;
    end else begin : g_half
      assign high_eff = div_q >> 1;
    end
  endgenerate

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      cnt     <= '0;
      div_q   <= '0;
      high_q  <= '0;
      clk_out <= 1'b0;
    end else if (!running) begin
      active  <= 1'b0;
      cnt     <= '0;
      clk_out <= 1'b0;
    end else if (!active || wrap) begin
      active  <= 1'b1;
      div_q   <= div_val;
      high_q  <= high_val;
      cnt     <= '0;
      clk_out <= 1'b1;
    end else begin
      cnt     <= cnt_nx;
      clk_out <= (cnt_nx <= high_eff);
    end
  end

  // R1
  gated_low_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    (div_val == '0) |=> !clk_out);

  // R5
  start_high_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    (!active && div_val != '0) |=> (clk_out && cnt == '0));

  // R3
  cnt_bound_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    active |-> (cnt <= div_q && div_q != '0));

  // R6
  hold_mid_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    (active && running && !wrap) |=> ($stable(div_q) && $stable(high_q)));

  // R4
  clamp_high_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    (HAS_HIGH && active && high_q >= div_q) |-> clk_out);

endmodule

// File: tb/sample_clk_div_tb.sv
`timescale 1ns/1ps
module sample_clk_div_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] div_a = '0, high_a = '0, div_b = '0, high_b = '0;
  logic out_a, run_a, out_b, run_b;
  int   n_tests = 0, n_fail = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  sample_clk_div #(.W(W), .HAS_HIGH(1'b1)) dut_i (
    .clk_in(clk), .rst_n(rst_n), .div_val(div_a), .high_val(high_a),
    .clk_out(out_a), .running(run_a));

  sample_clk_div #(.W(W), .HAS_HIGH(1'b0)) dut_half_i (
    .clk_in(clk), .rst_n(rst_n), .div_val(div_b), .high_val(high_b),
    .clk_out(out_b), .running(run_b));

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic gate_a(input int cycles);
    div_a = '0;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic wave_a(input string req, input int n, input int hi_cycles, input int periods);
    for (int p = 0; p < periods; p++) begin
      int bad = 0;
      int highs = 0;
      for (int i = 0; i <= n; i++) begin
        @(negedge clk);
        if (out_a) highs++;
        if (out_a != (i < hi_cycles)) bad++;
      end
      chk(req, $sformatf("N=%0d period %0d high count", n, p), highs, hi_cycles);
      chk(req, $sformatf("N=%0d period %0d shape errors", n, p), bad, 0);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R8", "clk_out after reset", out_a, 0);
    chk("R8", "running after reset", run_a, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_gated;
    int highs = 0;
    high_a = 8'd3;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (out_a) highs++;
    end
    chk("R1", "high samples while gated", highs, 0);
    chk("R2", "running while gated", run_a, 0);
  endtask

  task automatic t_basic(input int n, input int h);
    gate_a(2);
    div_a = W'(n); high_a = W'(h);
    #0.5;
    chk("R2", "running after enable", run_a, 1);
    wave_a("R3", n, h + 1, 3);
  endtask

  task automatic t_first_edge;
    gate_a(3);
    div_a = 8'd5; high_a = 8'd1;
    @(negedge clk);
    chk("R5", "first sample after enable", out_a, 1);
  endtask

  task automatic t_clamp;
    gate_a(2);
    div_a = 8'd3; high_a = 8'd9;
    wave_a("R4", 3, 4, 3);
  endtask

  task automatic t_update;
    int bad = 0;
    gate_a(2);
    div_a = 8'd5; high_a = 8'd2;
    @(negedge clk); if (out_a != 1) bad++;
    @(negedge clk); if (out_a != 1) bad++;
    div_a = 8'd2; high_a = 8'd0;
    for (int i = 2; i <= 5; i++) begin
      @(negedge clk);
      if (out_a != (i <= 2)) bad++;
    end
    chk("R6", "old period kept after mid-period write", bad, 0);
    wave_a("R6", 2, 1, 2);
  endtask

  task automatic t_gate_mid;
    int highs = 0;
    gate_a(2);
    div_a = 8'd6; high_a = 8'd6;
    repeat (3) @(negedge clk);
    div_a = '0;
    #0.5;
    chk("R2", "running after clear", run_a, 0);
    @(negedge clk);
    chk("R1", "clk_out one edge after clear", out_a, 0);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (out_a) highs++;
    end
    chk("R1", "high samples after mid-period clear", highs, 0);
  endtask

  task automatic t_half(input int n);
    int bad = 0;
    int hi_cycles = n / 2 + 1;
    div_b = '0;
    repeat (2) @(negedge clk);
    div_b = W'(n); high_b = 8'd0;
    for (int p = 0; p < 2; p++)
      for (int i = 0; i <= n; i++) begin
        @(negedge clk);
        if (out_b != (i < hi_cycles)) bad++;
        high_b = W'(i * 37);
      end
    chk("R7", $sformatf("half-duty shape N=%0d", n), bad, 0);
    chk("R7", "running of half-duty variant", run_b, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_gated();
    t_basic(1, 0);
    t_basic(4, 1);
    t_basic(7, 7);
    t_basic(255, 127);
    t_first_edge();
    t_clamp();
    t_update();
    t_gate_mid();
    t_half(3);
    t_half(4);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule